// File: doc/BRIEF.md
# Low-Power Mode Controller

This block decides, for a small microcontroller, which clock domains run. It has three modes: run, idle and power-down. It drives separate clock enables for the CPU, for the peripherals and for the oscillator. It turns the raw reset pin into a qualified internal reset. It also drives fixed levels onto the bus strobes while the core is asleep. The CPU and the peripherals appear only through the enables they receive.

Software enters idle or power-down with a one-cycle request. In idle, only the CPU clock stops: timers, the serial port, interrupt logic and RAM keep their clocks, and all state is held. Idle is left on a pending enabled interrupt or on activity at the reset pin. Power-down stops the oscillator too, and only a qualified reset ends it.

When the reset pin wakes the core from idle, the CPU runs again until the reset has qualified. During that window internal RAM writes are blocked, while port writes stay allowed. A reset reinitialises the register state but not the RAM, so the block issues no RAM clear.

Top module: `lpm_ctrl`

## Requirements
- R1: `int_rst` rises one clock after the clock edge that samples the RST_MC-th `mc_tick` (default 2), counting only ticks seen while `rst_pin` has been high without a break. A low `rst_pin` clears the count, and `int_rst` falls one clock after `rst_pin` is sampled low.
- R2: After `rst_ni` and in run mode, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `strb_force`, `strb_level` and `bus_float` are 0.
- R3: An `idle_req` sampled in run mode enters idle at that edge: `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R4: In idle, an `irq_pending` sampled at an edge returns the block to run mode at that edge.
- R5: A `pdown_req` sampled in run mode enters power-down at that edge: `cpu_clk_en` and `per_clk_en` are 0, and `osc_en` is 0 while `rst_pin` is low.
- R6: When `idle_req` and `pdown_req` are sampled together in run mode, power-down is entered.
- R7: In power-down, `irq_pending`, `idle_req` and `pdown_req` have no effect. `osc_en` follows `rst_pin` so the oscillator can restart for reset qualification.
- R8: A high `int_rst` sampled at an edge puts the block in run mode from any mode.
- R9: A high `rst_pin` sampled in idle returns the CPU to run at that edge and sets `ram_wr_block`. `ram_wr_block` clears at the edge that samples `int_rst` high or `rst_pin` low.
- R10: `strb_force` is 1 in idle and power-down. `strb_level` is all ones in idle and all zeros in power-down, and reads 0 when `strb_force` is 0.
- R11: `bus_float` is 1 exactly when the block is in idle or power-down and `ext_code` is 1; it follows `ext_code` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | Raw external reset pin, active high |
| mc_tick | input | 1 | One-clock strobe per machine cycle |
| idle_req | input | 1 | Software request to enter idle |
| pdown_req | input | 1 | Software request to enter power-down |
| irq_pending | input | 1 | An enabled interrupt is pending |
| ext_code | input | 1 | External program memory selected |
| int_rst | output | 1 | Qualified internal reset |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| ram_wr_block | output | 1 | Blocks internal RAM writes |
| strb_force | output | 1 | Bus strobes are forced |
| strb_level | output | N_STRB | Forced levels for address-latch and program-store strobes |
| bus_float | output | 1 | Multiplexed low address/data port floats |

## Verification
The reset pin is driven in three ways. A pulse too short to cover two machine cycles must leave `int_rst` low. A long hold must raise `int_rst` on the exact cycle after the second tick. A pin that goes high during idle must wake the CPU early with RAM writes blocked. Low-power entries are tried with idle alone, power-down alone and both requests together, which shows the priority. Interrupts and new requests are sent both in idle and in power-down; this separates the mode that an interrupt may wake from the one it must not. `ext_code` is toggled in every mode to show that the bus float depends on the mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      LPM_RUN  = 2'd0,
      LPM_IDLE = 2'd1,
      LPM_DOWN = 2'd2
   } lpm_mode_e;

   function automatic int unsigned cnt_bits(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/lpm_rst_qual.sv
module lpm_rst_qual #(
   parameter int unsigned RST_MC = 2
) (
   input  logic clk,
   input  logic rst_ni,
   input  logic rst_pin,
   input  logic mc_tick,
   output logic int_rst
);
   localparam int unsigned CW = lpm_pkg::cnt_bits(RST_MC);
   localparam logic [CW-1:0] LIMIT = CW'(RST_MC);

   logic [CW-1:0] cnt_q, cnt_d;

   // r1_ counts unbroken machine cycles with the pin high, saturating at the limit
   always_comb begin
      cnt_d = cnt_q;
      if (!rst_pin)
         cnt_d = '0;
      else if (mc_tick && (cnt_q != LIMIT))
         cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign int_rst = (cnt_q == LIMIT);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm (
   input  logic               clk,
   input  logic               rst_ni,
   input  logic               int_rst,
   input  logic               rst_pin,
   input  logic               idle_req,
   input  logic               pdown_req,
   input  logic               irq_pending,
   output lpm_pkg::lpm_mode_e mode,
   output logic               guard
);
   import lpm_pkg::*;

   lpm_mode_e mode_q, mode_d;
   logic      guard_q, guard_d;

   always_comb begin
      mode_d = mode_q;
      if (int_rst) begin
         mode_d = LPM_RUN;                                  // R8
      end else begin
         unique case (mode_q)
            LPM_RUN: begin
               if (pdown_req)     mode_d = LPM_DOWN;        // R5, R6 priority
               else if (idle_req) mode_d = LPM_IDLE;        // R3
            end
            LPM_IDLE: begin
               if (irq_pending || rst_pin) mode_d = LPM_RUN; // R4, R9
            end
            LPM_DOWN: mode_d = LPM_DOWN;                    // R7
            default:  mode_d = LPM_RUN;
         endcase
      end
   end

   // R9: window between a pin-driven idle wake-up and the qualified reset
   always_comb begin
      guard_d = rst_pin && !int_rst && (guard_q || (mode_q == LPM_IDLE));
   end

   always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q  <= LPM_RUN;
         guard_q <= 1'b0;
      end else begin
         mode_q  <= mode_d;
         guard_q <= guard_d;
      end
   end

   assign mode  = mode_q;
   assign guard = guard_q;
endmodule

// File: rtl/lpm_pin_force.sv
module lpm_pin_force #(
   parameter int unsigned           N_STRB   = 2,
   parameter logic [N_STRB-1:0]     IDLE_LVL = '1,
   parameter logic [N_STRB-1:0]     DOWN_LVL = '0
) (
   input  lpm_pkg::lpm_mode_e mode,
   input  logic               ext_code,
   output logic               strb_force,
   output logic [N_STRB-1:0]  strb_level,
   output logic               bus_float
);
   import lpm_pkg::*;

   logic asleep;
   assign asleep     = (mode != LPM_RUN);
   assign strb_force = asleep;                   // R10
   assign bus_float  = asleep && ext_code;       // R11

   for (genvar i = 0; i < N_STRB; i++) begin : g_strb
      always_comb begin
         unique case (mode)
            LPM_IDLE: strb_level[i] = IDLE_LVL[i];
            LPM_DOWN: strb_level[i] = DOWN_LVL[i];
            default:  strb_level[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
   parameter int unsigned       RST_MC   = 2,
   parameter int unsigned       N_STRB   = 2,
   parameter logic [N_STRB-1:0] IDLE_LVL = '1,
   parameter logic [N_STRB-1:0] DOWN_LVL = '0
) (
   input  logic              clk,
   input  logic              rst_ni,
   input  logic              rst_pin,
   input  logic              mc_tick,
   input  logic              idle_req,
   input  logic              pdown_req,
   input  logic              irq_pending,
   input  logic              ext_code,
   output logic              int_rst,
   output logic              cpu_clk_en,
   output logic              per_clk_en,
   output logic              osc_en,
   output logic              ram_wr_block,
   output logic              strb_force,
   output logic [N_STRB-1:0] strb_level,
   output logic              bus_float
);
   import lpm_pkg::*;

   if (RST_MC < 1) begin : g_bad_rst_mc
      $error("lpm_ctrl: RST_MC must be at least 1");
   end
   if (N_STRB < 1) begin : g_bad_n_strb
      $error("lpm_ctrl: N_STRB must be at least 1");
   end

   lpm_mode_e mode;
   logic      guard;

   lpm_rst_qual #(.RST_MC(RST_MC)) i_rst_qual (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .rst_pin (rst_pin),
      .mc_tick (mc_tick),
      .int_rst (int_rst)
   );

   lpm_mode_fsm i_mode_fsm (
      .clk         (clk),
      .rst_ni      (rst_ni),
      .int_rst     (int_rst),
      .rst_pin     (rst_pin),
      .idle_req    (idle_req),
      .pdown_req   (pdown_req),
      .irq_pending (irq_pending),
      .mode        (mode),
      .guard       (guard)
   );

   lpm_pin_force #(
      .N_STRB   (N_STRB),
      .IDLE_LVL (IDLE_LVL),
      .DOWN_LVL (DOWN_LVL)
   ) i_pin_force (
      .mode       (mode),
      .ext_code   (ext_code),
      .strb_force (strb_force),
      .strb_level (strb_level),
      .bus_float  (bus_float)
   );

   // R2, R3, R5, R7: clock-enable map per mode
   assign cpu_clk_en   = (mode == LPM_RUN);
   assign per_clk_en   = (mode != LPM_DOWN);
   assign osc_en       = (mode != LPM_DOWN) || rst_pin;
   assign ram_wr_block = guard;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
   parameter int unsigned N_STRB = 2
) (
   input logic              clk,
   input logic              rst_ni,
   input logic              rst_pin,
   input logic              int_rst,
   input logic              cpu_clk_en,
   input logic              per_clk_en,
   input logic              osc_en,
   input logic              ram_wr_block,
   input logic              strb_force,
   input logic [N_STRB-1:0] strb_level,
   input logic              bus_float
);
   a_r1_release: assert property (@(posedge clk) disable iff (!rst_ni)
      !rst_pin |=> !int_rst);

   a_r1_qualified: assert property (@(posedge clk) disable iff (!rst_ni)
      $rose(int_rst) |-> $past(rst_pin));

   a_r5_osc_off: assert property (@(posedge clk) disable iff (!rst_ni)
      (!per_clk_en && !rst_pin) |-> !osc_en);

   a_r7_down_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
      (!per_clk_en && !int_rst) |=> !per_clk_en);

   a_r8_reset_runs: assert property (@(posedge clk) disable iff (!rst_ni)
      int_rst |=> cpu_clk_en);

   a_r9_block_pin: assert property (@(posedge clk) disable iff (!rst_ni)
      ram_wr_block |-> $past(rst_pin));

   a_r10_idle_lvl: assert property (@(posedge clk) disable iff (!rst_ni)
      (strb_force && per_clk_en) |-> (strb_level == '1));

   a_r10_down_lvl: assert property (@(posedge clk) disable iff (!rst_ni)
      (strb_force && !per_clk_en) |-> (strb_level == '0));

   a_r11_no_float_run: assert property (@(posedge clk) disable iff (!rst_ni)
      !strb_force |-> !bus_float);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_STRB(N_STRB)) i_lpm_ctrl_chk (
   .clk          (clk),
   .rst_ni       (rst_ni),
   .rst_pin      (rst_pin),
   .int_rst      (int_rst),
   .cpu_clk_en   (cpu_clk_en),
   .per_clk_en   (per_clk_en),
   .osc_en       (osc_en),
   .ram_wr_block (ram_wr_block),
   .strb_force   (strb_force),
   .strb_level   (strb_level),
   .bus_float    (bus_float)
);

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int RST_MC     = 2;
   localparam int TICK_DIV   = 6;

   logic clk = 1'b0;
   logic rst_ni = 1'b0;
   logic rst_pin = 1'b0, mc_tick = 1'b0, idle_req = 1'b0, pdown_req = 1'b0;
   logic irq_pending = 1'b0, ext_code = 1'b0;
   logic int_rst, cpu_clk_en, per_clk_en, osc_en, ram_wr_block, strb_force, bus_float;
   logic [1:0] strb_level;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   lpm_ctrl i_lpm_ctrl (
      .clk(clk), .rst_ni(rst_ni), .rst_pin(rst_pin), .mc_tick(mc_tick),
      .idle_req(idle_req), .pdown_req(pdown_req), .irq_pending(irq_pending),
      .ext_code(ext_code), .int_rst(int_rst), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .osc_en(osc_en), .ram_wr_block(ram_wr_block),
      .strb_force(strb_force), .strb_level(strb_level), .bus_float(bus_float)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // machine-cycle strobe, one clock in every TICK_DIV
   int div = 0;
   always @(posedge clk) begin
      #1;
      mc_tick = (div == TICK_DIV-1);
      div = (div + 1) % TICK_DIV;
   end

   // behavioural reference: 0 run, 1 idle, 2 power-down
   int m_mode = 0, m_cnt = 0;
   bit m_blk = 0;
   always @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
         m_mode = 0; m_cnt = 0; m_blk = 0;
      end else begin
         int  old_mode;
         bit  qual;
         old_mode = m_mode;
         qual = (m_cnt >= RST_MC);
         if (qual) m_mode = 0;
         else if (old_mode == 0 && pdown_req) m_mode = 2;
         else if (old_mode == 0 && idle_req) m_mode = 1;
         else if (old_mode == 1 && (irq_pending || rst_pin)) m_mode = 0;
         if (!rst_pin || qual) m_blk = 0;
         else if (old_mode == 1) m_blk = 1;
         if (!rst_pin) m_cnt = 0;
         else if (mc_tick && m_cnt < RST_MC) m_cnt++;
      end
   end

   task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         chk({1'b0, int_rst}, {1'b0, m_cnt >= RST_MC}, "R1 int_rst");
         chk({1'b0, cpu_clk_en}, {1'b0, m_mode == 0}, "R2 cpu_clk_en");
         chk({1'b0, per_clk_en}, {1'b0, m_mode != 2}, "R5 per_clk_en");
         chk({1'b0, osc_en}, {1'b0, (m_mode != 2) || rst_pin}, "R7 osc_en");
         chk({1'b0, ram_wr_block}, {1'b0, m_blk}, "R9 ram_wr_block");
         chk({1'b0, strb_force}, {1'b0, m_mode != 0}, "R10 strb_force");
         chk(strb_level, (m_mode == 1) ? 2'b11 : 2'b00, "R10 strb_level");
         chk({1'b0, bus_float}, {1'b0, (m_mode != 0) && ext_code}, "R11 bus_float");
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic pulse_idle();
      idle_req = 1'b1; cyc(1); idle_req = 1'b0;
   endtask

   task automatic pulse_down();
      pdown_req = 1'b1; cyc(1); pdown_req = 1'b0;
   endtask

   task automatic full_reset();
      rst_pin = 1'b1; cyc(3 * TICK_DIV); rst_pin = 1'b0; cyc(2);
   endtask

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      cyc(3); rst_ni = 1'b1; cyc(2);
      @(negedge clk); chk({1'b0, cpu_clk_en}, 2'd1, "R2 reset state run");

      // R1 short pulse must not qualify
      rst_pin = 1'b1; cyc(4); rst_pin = 1'b0; cyc(2);
      @(negedge clk); chk({1'b0, int_rst}, 2'd0, "R1 short pulse");
      rst_pin = 1'b1; cyc(3 * TICK_DIV);
      @(negedge clk); chk({1'b0, int_rst}, 2'd1, "R1 qualified");
      rst_pin = 1'b0; cyc(2);

      // R3 / R4 / R11 idle
      pulse_idle();
      @(negedge clk); chk({1'b0, cpu_clk_en}, 2'd0, "R3 cpu stopped");
      chk({1'b0, per_clk_en}, 2'd1, "R3 peripherals run");
      ext_code = 1'b1; cyc(1);
      @(negedge clk); chk({1'b0, bus_float}, 2'd1, "R11 float in idle");
      chk(strb_level, 2'b11, "R10 idle level");
      irq_pending = 1'b1; cyc(1); irq_pending = 1'b0;
      @(negedge clk); chk({1'b0, cpu_clk_en}, 2'd1, "R4 irq wakes idle");
      chk({1'b0, bus_float}, 2'd0, "R11 no float in run");

      // R5 / R7 / R8 power-down
      pulse_down();
      @(negedge clk); chk({1'b0, osc_en}, 2'd0, "R5 osc off");
      irq_pending = 1'b1; idle_req = 1'b1; cyc(3); irq_pending = 1'b0; idle_req = 1'b0;
      @(negedge clk); chk({1'b0, per_clk_en}, 2'd0, "R7 irq ignored");
      chk(strb_level, 2'b00, "R10 down level");
      ext_code = 1'b0; cyc(1);
      @(negedge clk); chk({1'b0, bus_float}, 2'd0, "R11 internal code holds");
      full_reset();
      @(negedge clk); chk({1'b0, cpu_clk_en}, 2'd1, "R8 reset ends power-down");

      // R6 both requests
      idle_req = 1'b1; pdown_req = 1'b1; cyc(1); idle_req = 1'b0; pdown_req = 1'b0;
      @(negedge clk); chk({1'b0, per_clk_en}, 2'd0, "R6 power-down wins");
      full_reset();

      // R9 reset pin during idle
      pulse_idle(); cyc(2);
      rst_pin = 1'b1; cyc(1);
      @(negedge clk); chk({1'b0, cpu_clk_en}, 2'd1, "R9 early wake");
      chk({1'b0, ram_wr_block}, 2'd1, "R9 ram blocked");
      cyc(3 * TICK_DIV);
      @(negedge clk); chk({1'b0, ram_wr_block}, 2'd0, "R9 block cleared");
      rst_pin = 1'b0; cyc(2);

      // R9 glitch in idle: wakes, then the block clears with the pin
      pulse_idle(); cyc(1);
      rst_pin = 1'b1; cyc(2); rst_pin = 1'b0; cyc(1);
      @(negedge clk); chk({1'b0, ram_wr_block}, 2'd0, "R9 glitch clears");
      chk({1'b0, int_rst}, 2'd0, "R1 glitch unqualified");
      cyc(3);
      finish_run();
   end
endmodule